// File: doc/BRIEF.md
# Pixel Input Inverse-Knee, Gain and Black-Offset Stage

This block sits at the very front of a camera video pipeline and receives one 10-bit sample per clock from an external converter. First it reverses an analog knee compression. A sample at or below a programmable breakpoint passes through unchanged. Above the breakpoint, the compressed segment is stretched back out by a factor of two, because that segment was recorded at half the slope of the linear part.

The restored sample is then multiplied by a digital gain between 1x and 16x and saturated to the output range. Finally a black offset is taken away, with the result floored at zero. The incoming black level normally sits at code 48, so after reset the offset defaults to 48. Software can load a different offset when noise moves the black level.

The three settings load together from parallel inputs on a single strobe. A valid flag travels with each sample through a fixed three-stage pipeline.

Top module: `pix_front_expand`

## Requirements
- R1: After reset, out_valid and out_data are 0 and the settings are breakpoint 1023, gain code 16 (1x) and black offset 48.
- R2: A sample taken with in_valid high at clock edge n appears with out_valid high just after edge n+2, so three registers deep. out_valid is low in every cycle that has no matching input sample.
- R3: With breakpoint k, a sample x <= k leaves the inverse-knee step as x. A sample x > k leaves it as k + 2*(x - k), in 11 bits.
- R4: The gain code is an unsigned 9-bit value with 4 fraction bits (16 means 1x). Codes below 16 are treated as 16 and codes above 256 as 256, and the scaled value is floor(e*g/16).
- R5: A scaled value above 4095 is saturated to 4095.
- R6: The output is the scaled value minus the black offset (12-bit) when that difference is positive, and 0 otherwise.
- R7: With the reset defaults, an input of 100 gives an output of 52.
- R8: cfg_knee, cfg_gain and cfg_black are captured only on a clock edge where cfg_load is high. Without cfg_load, changes on those inputs have no effect on the output.
- R9: out_data keeps its last value in every cycle where out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Captures the three setting inputs |
| cfg_knee | input | 10 | Inverse-knee breakpoint |
| cfg_gain | input | 9 | Gain code, 4 fraction bits |
| cfg_black | input | 12 | Black offset subtracted at the end |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | 10 | Converter sample |
| out_valid | output | 1 | Output sample qualifier |
| out_data | output | 12 | Processed sample |

## Verification
Several properties are checked on every cycle: the three-cycle valid timing in both directions, the held output while no sample is valid, and that settings change only under the load strobe. They also check that the stored gain never leaves the 1x to 16x range, that samples at or below the breakpoint pass the first stage untouched, and that the last stage never exceeds its input and floors to zero. The exact arithmetic can only be shown by the bench's scenarios: the doubling above the breakpoint, the fractional truncation of the gain, saturation at 4095 and the default offset of 48. Those scenarios compare outputs against values worked out from the requirements.

// File: rtl/pix_front_expand.sv
module pix_front_expand #(
  parameter int IN_W      = 10,
  parameter int OUT_W     = 12,
  parameter int GAIN_W    = 9,
  parameter int GAIN_FRAC = 4,
  parameter int GAIN_MIN  = 16,
  parameter int GAIN_MAX  = 256,
  parameter int KNEE_RST  = 1023,
  parameter int BLACK_RST = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [IN_W-1:0]  cfg_knee,
  input  logic [GAIN_W-1:0] cfg_gain,
  input  logic [OUT_W-1:0] cfg_black,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);

  localparam int EXP_W  = IN_W + 1;
  localparam int PROD_W = EXP_W + GAIN_W;
  localparam logic [GAIN_W-1:0] G_LO    = GAIN_W'(GAIN_MIN);
  localparam logic [GAIN_W-1:0] G_HI    = GAIN_W'(GAIN_MAX);
  localparam logic [OUT_W-1:0]  OUT_MAX = '1;

  logic [IN_W-1:0]   knee_q;
  logic [GAIN_W-1:0] gain_q;
  logic [OUT_W-1:0]  black_q;
  logic [GAIN_W-1:0] gain_lim;

  assign gain_lim = (cfg_gain < G_LO) ? G_LO : (cfg_gain > G_HI) ? G_HI : cfg_gain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      knee_q  <= IN_W'(KNEE_RST);
      gain_q  <= G_LO;
      black_q <= OUT_W'(BLACK_RST);
    end else if (cfg_load) begin
      knee_q  <= cfg_knee;
      gain_q  <= gain_lim;
      black_q <= cfg_black;
    end
  end

  // stage 1: inverse knee
  logic             v1_q;
  logic [EXP_W-1:0] s1_q;
  logic [EXP_W-1:0] expd;

  assign expd = (in_data > knee_q) ? ({in_data, 1'b0} - {1'b0, knee_q}) : {1'b0, in_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      s1_q <= '0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) s1_q <= expd;
    end
  end

  // stage 2: gain with saturation
  logic              v2_q;
  logic [OUT_W-1:0]  s2_q;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] scaled;
  logic [OUT_W-1:0]  sat;

  assign prod   = PROD_W'(s1_q) * PROD_W'(gain_q);
  assign scaled = prod >> GAIN_FRAC;
  assign sat    = (|scaled[PROD_W-1:OUT_W]) ? OUT_MAX : scaled[OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2_q <= 1'b0;
      s2_q <= '0;
    end else begin
      v2_q <= v1_q;
      if (v1_q) s2_q <= sat;
    end
  end

  // stage 3: black offset, floored at zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= v2_q;
      if (v2_q) out_data <= (s2_q > black_q) ? (s2_q - black_q) : '0;
    end
  end

  a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##2 out_valid);
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##2 !out_valid);
  a_r3_below_knee: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data <= knee_q) |=> (s1_q == {1'b0, $past(in_data)}));
  a_r3_above_knee: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data > knee_q) |=> (s1_q > {1'b0, $past(in_data)}));
  a_r4_gain_range: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_q >= G_LO) && (gain_q <= G_HI));
  a_r6_not_above: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data <= $past(s2_q)));
  a_r6_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (v2_q && s2_q <= black_q) |=> (out_data == '0));
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> ($stable(knee_q) && $stable(gain_q) && $stable(black_q)));
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

endmodule

// File: tb/pix_front_expand_tb.sv
module pix_front_expand_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [9:0]  cfg_knee = '0;
  logic [8:0]  cfg_gain = '0;
  logic [11:0] cfg_black = '0;
  logic        in_valid = 1'b0;
  logic [9:0]  in_data = '0;
  logic        out_valid;
  logic [11:0] out_data;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pix_front_expand u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_knee(cfg_knee),
    .cfg_gain(cfg_gain), .cfg_black(cfg_black), .in_valid(in_valid),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  localparam int NV = 14;
  // rows: R6 R6 R3 R3 R3 R3 R5 R5 R4 R4 R4 R4 R5/R6 R3/R4/R6
  localparam int T_KNEE  [NV] = '{1023,1023, 400, 400, 400,   0,   0,   0,1023,1023,1023,1023,1023, 512};
  localparam int T_GAIN  [NV] = '{  16,  16,  16,  16,  16,  16,  32,  48,  24,  20,   5, 300, 256,  40};
  localparam int T_BLACK [NV] = '{  48,  48,   0,   0,   0,   0,   0,   0,  10,   0,   0,   0, 100,2000};
  localparam int T_IN    [NV] = '{ 500,  30, 600, 400, 401,1023,1023,1023, 100,   7, 200, 200, 255, 900};
  localparam int T_EXP   [NV] = '{ 452,   0, 800, 400, 402,2046,4092,4095, 140,   8, 200,3200,3980,1220};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_cfg(input int k, input int g, input int b);
    @(negedge clk);
    cfg_knee = 10'(k); cfg_gain = 9'(g); cfg_black = 12'(b); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic send_one(input string req, input int x, input int exp);
    @(negedge clk);
    in_valid = 1'b1; in_data = 10'(x);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check({req, " valid"}, int'(out_valid), 1);
    check(req, int'(out_data), exp);
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 out_valid at reset", int'(out_valid), 0);
    check("R1 out_data at reset", int'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7, R1: defaults 1023 / 1x / 48
    send_one("R7 default offset", 100, 52);

    // R8: settings change without load must be ignored
    @(negedge clk);
    cfg_knee = 10'd0; cfg_gain = 9'd256; cfg_black = 12'd0;
    send_one("R8 no load ignored", 100, 52);

    // R9: output held while idle
    repeat (4) @(negedge clk);
    check("R9 idle valid", int'(out_valid), 0);
    check("R9 idle hold", int'(out_data), 52);

    // R2: back-to-back stream with defaults restored
    load_cfg(1023, 16, 48);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (i >= 3 && i < 7) begin
        check("R2 stream valid", int'(out_valid), 1);
        check("R2 stream data", int'(out_data), 12 + 10 * (i - 3));
      end else begin
        check("R2 stream gap", int'(out_valid), 0);
      end
      if (i < 4) begin
        in_valid = 1'b1; in_data = 10'(60 + 10 * i);
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end

    // table of settings and samples: R3 R4 R5 R6
    for (int r = 0; r < NV; r++) begin
      load_cfg(T_KNEE[r], T_GAIN[r], T_BLACK[r]);
      send_one($sformatf("R3/R4/R5/R6 row %0d", r), T_IN[r], T_EXP[r]);
    end

    // R1: reset mid-run restores defaults
    load_cfg(0, 200, 0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears data", int'(out_data), 0);
    rst_n = 1'b1;
    send_one("R1 defaults after reset", 100, 52);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule